// File: doc/BRIEF.md
# Turbo Frequency Budget Governor

This block chooses the frequency ratio for a cluster of cores. Software asks for a performance level. When that level is at or below the guaranteed ratio, the block grants it one cycle later, but it never grants less than the energy-efficient floor. Speeds below the floor are left to a separate throttling mechanism. When software asks for more than the guaranteed ratio, the block itself decides how much of the turbo range to grant. That decision depends on two things: how many cores are awake, and how much energy budget is left.

The energy budget is a saturating accumulator. Every cycle it gains the difference between the power limit and the measured power, so it fills while the cluster runs cool or idles and drains while the cluster runs hot. Power-gated cores free thermal headroom, so the turbo ceiling is higher when fewer cores are active. Once the budget is empty and power is still above the limit, the grant steps down by one ratio at each evaluation tick until it reaches the guaranteed ratio. This brings sustained power back to the limit.

Top module: `turbo_budget_gov`

## Requirements
- R1: While reset is asserted and after its release, `grant_ratio` is the floor ratio PN_RATIO (8) and `budget_lvl` is 0, until the first clock edge that processes input.
- R2: A request between PN_RATIO (8) and P1_RATIO (20), inclusive, appears unchanged on `grant_ratio` after the next clock edge, whatever the tick phase or budget.
- R3: A request below PN_RATIO is granted as PN_RATIO after the next edge. A request at or below P1_RATIO is never exceeded.
- R4: Each edge sets `budget_lvl` to the old level plus `tdp_limit` minus `pwr_meas`, clamped to 0 from below and to `budget_max` from above. Lowering `budget_max` takes effect in the same update.
- R5: The turbo ceiling for n active cores is P1_RATIO + TURBO_STEP*(NCORES+1-n). A count of 0 is treated as 1 and a count above NCORES as NCORES. With the defaults, 1/2/3/4 cores give 28/26/24/22. A request above the ceiling is granted the ceiling.
- R6: An evaluation tick occurs on every EVAL_CYC-th edge after reset release (edges EVAL_CYC, 2*EVAL_CYC, …). The grant rises above P1_RATIO only on a tick edge. Between ticks, a grant above P1_RATIO can only hold or fall.
- R7: On a tick edge with `budget_lvl` at 0, `pwr_meas` above `tdp_limit` and a request above P1_RATIO, the grant becomes the lower of the ceiling and one less than the old grant. It never goes below P1_RATIO. On a tick with budget left, the grant goes to the lower of the request and the ceiling.
- R8: When the ceiling or the request drops below the current turbo grant, the grant follows it down on the next edge, without waiting for a tick.
- R9: A request above P1_RATIO lifts a grant that is below P1_RATIO to P1_RATIO on the next edge, without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ratio | input | 8 | Frequency ratio requested by software |
| active_cores | input | 3 | Number of cores not power-gated |
| pwr_meas | input | 12 | Measured power this cycle, integer units |
| tdp_limit | input | 12 | Sustained power limit, same units |
| budget_max | input | 20 | Saturation ceiling of the energy budget |
| grant_ratio | output | 8 | Granted frequency ratio |
| budget_lvl | output | 20 | Current energy budget |

## Verification
The assertions assume that `tdp_limit` and `pwr_meas` fit within the budget width without wrapping, and that `budget_max` is a real ceiling for the accumulator. The bench keeps power values in the low hundreds and the budget ceiling at 1000 or below. The properties also take the active-core count as given and compare the grant against the ceiling computed one cycle earlier. The bench changes the core count only between edges, 1 ns after a clock edge, so every comparison refers to one stable count. The bench keeps its own count of edges since reset, so each turbo check is sampled right after a known tick edge.

// File: rtl/turbo_gov_pkg.sv
package turbo_gov_pkg;
    localparam int RATIO_W = 8;
    typedef logic [RATIO_W-1:0] ratio_t;

    function automatic ratio_t rmin(input ratio_t a, input ratio_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic ratio_t rmax(input ratio_t a, input ratio_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/gov_budget_acc.sv
module gov_budget_acc #(
    parameter int PWR_W = 12,
    parameter int BUD_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWR_W-1:0] pwr_meas,
    input  logic [PWR_W-1:0] tdp_limit,
    input  logic [BUD_W-1:0] budget_max,
    output logic [BUD_W-1:0] budget
);
    localparam int XW = BUD_W + 1;

    typedef struct packed {
        logic [BUD_W-1:0] level;
    } acc_t;

    acc_t st_d, st_q;
    logic [XW-1:0] credit, drain, diff;

    always_comb begin
        st_d   = st_q;
        credit = {1'b0, st_q.level} + {{(XW-PWR_W){1'b0}}, tdp_limit};
        drain  = {{(XW-PWR_W){1'b0}}, pwr_meas};
        diff   = credit - drain;
        if (credit < drain) begin
            st_d.level = '0;
        end else if (diff > {1'b0, budget_max}) begin
            st_d.level = budget_max;
        end else begin
            st_d.level = diff[BUD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign budget = st_q.level;

    AST_BUDGET_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> budget <= $past(budget_max)); // R4
    AST_BUDGET_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (budget == '0 && pwr_meas >= tdp_limit) |=> budget == '0); // R4
endmodule

// File: rtl/gov_eval_timer.sv
module gov_eval_timer #(
    parameter int EVAL_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (EVAL_CYC > 2) ? $clog2(EVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(EVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
endmodule

// File: rtl/gov_turbo_cap.sv
module gov_turbo_cap
    import turbo_gov_pkg::*;
#(
    parameter int NCORES     = 4,
    parameter int P1_RATIO   = 20,
    parameter int TURBO_STEP = 2,
    localparam int AC_W      = $clog2(NCORES + 1)
) (
    input  logic [AC_W-1:0] active_cores,
    output ratio_t          cap
);
    ratio_t cap_tbl [NCORES+1];

    for (genvar n = 0; n <= NCORES; n++) begin : g_tbl
        localparam int EFF = (n == 0) ? 1 : n;
        assign cap_tbl[n] = ratio_t'(P1_RATIO + TURBO_STEP * (NCORES + 1 - EFF));
    end

    logic [AC_W-1:0] sel;

    always_comb begin
        if (int'(active_cores) > NCORES) begin
            sel = AC_W'(NCORES);
        end else begin
            sel = active_cores;
        end
        cap = cap_tbl[sel];
    end
endmodule

// File: rtl/turbo_budget_gov.sv
module turbo_budget_gov
    import turbo_gov_pkg::*;
#(
    parameter int NCORES     = 4,
    parameter int PWR_W      = 12,
    parameter int BUD_W      = 20,
    parameter int EVAL_CYC   = 16,
    parameter int PN_RATIO   = 8,
    parameter int P1_RATIO   = 20,
    parameter int TURBO_STEP = 2,
    localparam int AC_W      = $clog2(NCORES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] req_ratio,
    input  logic [AC_W-1:0]    active_cores,
    input  logic [PWR_W-1:0]   pwr_meas,
    input  logic [PWR_W-1:0]   tdp_limit,
    input  logic [BUD_W-1:0]   budget_max,
    output logic [RATIO_W-1:0] grant_ratio,
    output logic [BUD_W-1:0]   budget_lvl
);
    localparam ratio_t PN  = ratio_t'(PN_RATIO);
    localparam ratio_t P1  = ratio_t'(P1_RATIO);
    localparam ratio_t TOP = ratio_t'(P1_RATIO + TURBO_STEP * NCORES);

    typedef struct packed {
        ratio_t grant;
    } gov_t;

    gov_t   st_d, st_q;
    logic   tick;
    logic   exhausted;
    ratio_t cap, tgt, stepped, lifted;
    logic [BUD_W-1:0] budget;

    gov_budget_acc #(.PWR_W(PWR_W), .BUD_W(BUD_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_meas   (pwr_meas),
        .tdp_limit  (tdp_limit),
        .budget_max (budget_max),
        .budget     (budget)
    );

    gov_eval_timer #(.EVAL_CYC(EVAL_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    gov_turbo_cap #(
        .NCORES     (NCORES),
        .P1_RATIO   (P1_RATIO),
        .TURBO_STEP (TURBO_STEP)
    ) u_cap (
        .active_cores (active_cores),
        .cap          (cap)
    );

    always_comb begin
        st_d      = st_q;
        exhausted = (budget == '0) && (pwr_meas > tdp_limit);
        tgt       = rmin(req_ratio, cap);
        stepped   = (st_q.grant > P1) ? (st_q.grant - 1'b1) : P1;
        lifted    = rmax(st_q.grant, P1);
        if (req_ratio <= P1) begin
            st_d.grant = rmax(req_ratio, PN);
        end else if (tick) begin
            st_d.grant = exhausted ? rmin(stepped, tgt) : tgt;
        end else begin
            st_d.grant = rmin(lifted, tgt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.grant <= PN;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_ratio = st_q.grant;
    assign budget_lvl  = budget;

    AST_GRANT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ratio >= PN && grant_ratio <= TOP); // R3
    AST_PASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ratio >= PN && req_ratio <= P1) |=> grant_ratio == $past(req_ratio)); // R2
    AST_NO_EXCEED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ratio <= P1) |=> grant_ratio <= rmax($past(req_ratio), PN)); // R3
    AST_UNDER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ratio > P1) |=> grant_ratio <= $past(cap)); // R5
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !(grant_ratio > P1 && grant_ratio > $past(grant_ratio))); // R6
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && exhausted && req_ratio > P1 && grant_ratio > P1)
            |=> (grant_ratio < $past(grant_ratio) && grant_ratio >= P1)); // R7
    AST_LIFT_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ratio > P1) |=> grant_ratio >= P1); // R9
endmodule

// File: tb/turbo_budget_gov_tb.sv
`timescale 1ns/1ps
module turbo_budget_gov_tb;
    localparam int E = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_ratio = 8'd15;
    logic [2:0]  active_cores = 3'd1;
    logic [11:0] pwr_meas = 12'd100;
    logic [11:0] tdp_limit = 12'd100;
    logic [19:0] budget_max = 20'd1000;
    logic [7:0]  grant_ratio;
    logic [19:0] budget_lvl;

    int n_chk = 0;
    int n_fail = 0;
    int bc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else bc <= bc + 1;
    end

    turbo_budget_gov u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_ratio    (req_ratio),
        .active_cores (active_cores),
        .pwr_meas     (pwr_meas),
        .tdp_limit    (tdp_limit),
        .budget_max   (budget_max),
        .grant_ratio  (grant_ratio),
        .budget_lvl   (budget_lvl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_tick();
        do begin
            @(posedge clk);
            #1;
        end while (bc % E != 0);
    endtask

    task automatic t_reset();
        step(2);
        chk(grant_ratio == 8'd8, "R1 grant at reset", grant_ratio, 8);
        chk(budget_lvl == 20'd0, "R1 budget at reset", budget_lvl, 0);
        rst_n = 1'b1;
        chk(grant_ratio == 8'd8, "R1 grant after release", grant_ratio, 8);
    endtask

    task automatic t_pass();
        req_ratio = 8'd15;
        step(1);
        chk(grant_ratio == 8'd15, "R2 pass 15", grant_ratio, 15);
        req_ratio = 8'd20;
        step(1);
        chk(grant_ratio == 8'd20, "R2 pass P1", grant_ratio, 20);
        req_ratio = 8'd8;
        wait_tick();
        chk(grant_ratio == 8'd8, "R2 pass floor on tick", grant_ratio, 8);
    endtask

    task automatic t_floor();
        req_ratio = 8'd3;
        step(1);
        chk(grant_ratio == 8'd8, "R3 below floor", grant_ratio, 8);
        req_ratio = 8'd0;
        step(E);
        chk(grant_ratio == 8'd8, "R3 zero request", grant_ratio, 8);
    endtask

    task automatic t_budget();
        pwr_meas = 12'd60;
        step(1);
        chk(budget_lvl == 20'd40, "R4 credit one", budget_lvl, 40);
        step(2);
        chk(budget_lvl == 20'd120, "R4 credit three", budget_lvl, 120);
        step(30);
        chk(budget_lvl == 20'd1000, "R4 saturate max", budget_lvl, 1000);
        pwr_meas = 12'd130;
        step(1);
        chk(budget_lvl == 20'd970, "R4 debit", budget_lvl, 970);
        budget_max = 20'd500;
        step(1);
        chk(budget_lvl == 20'd500, "R4 lowered max", budget_lvl, 500);
        budget_max = 20'd1000;
        pwr_meas = 12'd60;
        step(1);
    endtask

    task automatic t_turbo();
        req_ratio = 8'd15;
        wait_tick();
        req_ratio = 8'd40;
        active_cores = 3'd1;
        step(1);
        chk(grant_ratio == 8'd20, "R9 lift to P1", grant_ratio, 20);
        step(1);
        chk(grant_ratio == 8'd20, "R6 no rise off tick", grant_ratio, 20);
        wait_tick();
        chk(grant_ratio == 8'd28, "R5 one core cap", grant_ratio, 28);
        active_cores = 3'd2;
        step(1);
        chk(grant_ratio == 8'd26, "R8 two core drop", grant_ratio, 26);
        active_cores = 3'd0;
        wait_tick();
        chk(grant_ratio == 8'd28, "R5 zero cores as one", grant_ratio, 28);
        active_cores = 3'd3;
        req_ratio = 8'd23;
        step(1);
        chk(grant_ratio == 8'd23, "R8 request below cap", grant_ratio, 23);
        active_cores = 3'd4;
        req_ratio = 8'd40;
        wait_tick();
        chk(grant_ratio == 8'd22, "R5 four core cap", grant_ratio, 22);
        active_cores = 3'd1;
        wait_tick();
        chk(grant_ratio == 8'd28, "R7 tick with budget", grant_ratio, 28);
    endtask

    task automatic t_exhaust();
        int prev;
        int exp;
        pwr_meas = 12'd1000;
        step(3);
        chk(budget_lvl == 20'd0, "R4 drained", budget_lvl, 0);
        prev = grant_ratio;
        for (int i = 0; i < 10; i++) begin
            wait_tick();
            exp = (prev > 20) ? prev - 1 : 20;
            chk(grant_ratio == exp[7:0], "R7 step down", grant_ratio, exp);
            prev = grant_ratio;
        end
        pwr_meas = 12'd60;
        step(2);
        chk(grant_ratio == 8'd20, "R6 hold between ticks", grant_ratio, 20);
        wait_tick();
        chk(grant_ratio == 8'd28, "R7 recover with budget", grant_ratio, 28);
        req_ratio = 8'd20;
        step(1);
        chk(grant_ratio == 8'd20, "R3 request back at P1", grant_ratio, 20);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_floor();
        t_budget();
        t_turbo();
        t_exhaust();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule